// File: doc/BRIEF.md
# Wake-Pin Configuration with Hardware Lock

This block decides which of the upper four pins of an 8-bit port may wake a sleeping system, and at which level each of them does so. When a pin is enabled and its input matches the level chosen for it, the block raises a wake request toward a hibernation controller. A sticky status register records every pin that has produced a match, so software can later find out what caused the wake. Software clears that record with write-1-to-clear accesses.

The hibernation side drives a lock input. While the lock is high, writes to the enable and level registers are dropped without any indication, and the wake configuration stays fixed through the power-down. Dropping the lock makes both registers writable again. Status clearing is not affected by the lock. Writes take effect on the clock edge. Reads are combinational from the registered state.

Register map (byte offsets on a 4-bit address): enable at 0x0, level at 0x4, status at 0x8. In all three registers only bits 7..4 exist, and each of those bits belongs to the port pin with the same index.

Top module: `wake_pin_cfg`

## Requirements
- R1: While reset is active and immediately after it, the enable, level and status registers all read 0x00 and `wake_o` is low.
- R2: A write to offset 0x0 stores bits 7..4 as the per-pin wake enable. The new value reads back from the next clock edge.
- R3: Bits 3..0 of every register read as zero, and writing them has no effect.
- R4: A write to offset 0x4 stores bits 7..4 as the per-pin wake level. A level bit of 1 means the pin wakes when high, and 0 means it wakes when low.
- R5: `wake_o` is high one clock after any enabled pin in 7..4 equals its level bit. The enable and level values used are the ones held before that edge.
- R6: A pin whose enable bit is 0 never raises `wake_o` and never sets its status bit, whatever its input level.
- R7: A status bit (offset 0x8, bit n for pin n) sets one clock after pin n matches while enabled. It then stays set after the pin stops matching.
- R8: Writing offset 0x8 clears each status bit whose data bit is 1. If a bit is cleared and matched in the same cycle, it stays set.
- R9: While `lock_i` is high, writes to offsets 0x0 and 0x4 are ignored.
- R10: Once `lock_i` is low again, writes to offsets 0x0 and 0x4 take effect as in R2 and R4.
- R11: A read of any offset other than 0x0, 0x4 or 0x8 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Freezes the enable and level registers while high |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write byte offset |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read byte offset |
| rd_data_o | output | 8 | Combinational read data |
| pins_i | input | 8 | Port pin levels, assumed synchronous to `clk` |
| wake_o | output | 1 | Registered wake request |

## Verification
Every result of this block is due one edge after the stimulus that causes it:
- A register write shows up on the read port after that edge.
- A pin match shows up on both `wake_o` and the status register at that same edge.

Read data is combinational from the address, so a read needs no extra wait. The bench drives each vector on the falling edge. It then checks the read data and `wake_o` on the next falling edge, which is exactly one rising edge later. Its expected values therefore use the configuration held before each write, which is how the design behaves.

// File: rtl/wkcfg_pkg.sv
package wkcfg_pkg;
    localparam int PORT_W = 8;
    localparam int WAKE_LO = 4;
    localparam int WAKE_N = PORT_W - WAKE_LO;
    localparam int ADDR_W = 4;

    typedef logic [WAKE_N-1:0] wmask_t;

    typedef struct packed {
        wmask_t en;
        wmask_t lvl;
    } cfg_state_t;

    typedef struct packed {
        wmask_t sts;
        logic   wake;
    } sts_state_t;
endpackage

// File: rtl/wkcfg_regs.sv
module wkcfg_regs
    import wkcfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lock_i,
    input  logic   wr_en_sel_i,
    input  logic   wr_lvl_sel_i,
    input  wmask_t wdata_i,
    output wmask_t en_o,
    output wmask_t lvl_o
);
    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!lock_i) begin
            if (wr_en_sel_i)  cfg_d.en  = wdata_i;
            if (wr_lvl_sel_i) cfg_d.lvl = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_o  = cfg_q.en;
    assign lvl_o = cfg_q.lvl;

    assert_locked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> ($stable(en_o) && $stable(lvl_o)));
endmodule

// File: rtl/wkcfg_match.sv
module wkcfg_match
    import wkcfg_pkg::*;
(
    input  wmask_t pins_i,
    input  wmask_t en_i,
    input  wmask_t lvl_i,
    output wmask_t hit_o
);
    for (genvar i = 0; i < WAKE_N; i++) begin : g_pin
        assign hit_o[i] = en_i[i] & (pins_i[i] == lvl_i[i]);
    end
endmodule

// File: rtl/wkcfg_status.sv
module wkcfg_status
    import wkcfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  wmask_t hit_i,
    input  wmask_t clr_i,
    output wmask_t sts_o,
    output logic   wake_o
);
    sts_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sts  = (st_q.sts & ~clr_i) | hit_i;
        st_d.wake = |hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o  = st_q.sts;
    assign wake_o = st_q.wake;

    // R7: a bit that was set and not cleared remains set
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sts_o) & ~$past(clr_i)) & ~sts_o) == '0));

    // R8: a match beats a simultaneous clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hit_i) & ~sts_o) == '0));
endmodule

// File: rtl/wake_pin_cfg.sv
module wake_pin_cfg
    import wkcfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OFS_EN  = 4'h0,
    parameter logic [ADDR_W-1:0] OFS_LVL = 4'h4,
    parameter logic [ADDR_W-1:0] OFS_STS = 4'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [PORT_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [PORT_W-1:0] rd_data_o,
    input  logic [PORT_W-1:0] pins_i,
    output logic              wake_o
);
    localparam logic [WAKE_LO-1:0] LOW_ZERO = '0;

    wmask_t wdata_hi, pins_hi, en_q, lvl_q, hit, sts_q, clr;
    logic   sel_en, sel_lvl;

    assign wdata_hi = wr_data_i[PORT_W-1:WAKE_LO];
    assign pins_hi  = pins_i[PORT_W-1:WAKE_LO];
    assign sel_en   = wr_en_i && (wr_addr_i == OFS_EN);
    assign sel_lvl  = wr_en_i && (wr_addr_i == OFS_LVL);
    assign clr      = (wr_en_i && (wr_addr_i == OFS_STS)) ? wdata_hi : '0;

    wkcfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_i      (lock_i),
        .wr_en_sel_i (sel_en),
        .wr_lvl_sel_i(sel_lvl),
        .wdata_i     (wdata_hi),
        .en_o        (en_q),
        .lvl_o       (lvl_q)
    );

    wkcfg_match u_match (
        .pins_i(pins_hi),
        .en_i  (en_q),
        .lvl_i (lvl_q),
        .hit_o (hit)
    );

    wkcfg_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (hit),
        .clr_i (clr),
        .sts_o (sts_q),
        .wake_o(wake_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == OFS_EN)       rd_data_o = {en_q, LOW_ZERO};
        else if (rd_addr_i == OFS_LVL) rd_data_o = {lvl_q, LOW_ZERO};
        else if (rd_addr_i == OFS_STS) rd_data_o = {sts_q, LOW_ZERO};
    end

    // R7: every wake request is backed by a recorded cause
    assert_wake_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (sts_q != '0));

    // R3: low nibble never reads back non-zero
    assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (rd_data_o[WAKE_LO-1:0] == '0));

    // R6: a disabled pin never raises its status bit
    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(en_q) & ~$past(sts_q) & sts_q) == '0));
endmodule

// File: tb/wake_pin_cfg_tb_top.sv
module wake_pin_cfg_tb_top;
    localparam int NV = 15;
    // {req[3:0], lock, we, waddr[3:0], wdata[7:0], pins[7:0], raddr[3:0], exp_rd[7:0], exp_wake}
    localparam logic [38:0] VEC [NV] = '{
        {4'd4,  1'b0, 1'b1, 4'h4, 8'hA5, 8'h50, 4'h4, 8'hA0, 1'b0}, // R4 level store
        {4'd3,  1'b0, 1'b1, 4'h0, 8'h0F, 8'h50, 4'h0, 8'h00, 1'b0}, // R3 low bits dropped
        {4'd2,  1'b0, 1'b1, 4'h0, 8'h80, 8'h00, 4'h0, 8'h80, 1'b0}, // R2 enable pin7
        {4'd5,  1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 4'h8, 8'h00, 1'b0}, // R5 no match
        {4'd5,  1'b0, 1'b0, 4'h0, 8'h00, 8'h80, 4'h8, 8'h80, 1'b1}, // R5 high-level match
        {4'd7,  1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 4'h8, 8'h80, 1'b0}, // R7 sticky
        {4'd6,  1'b0, 1'b0, 4'h0, 8'h00, 8'h70, 4'h8, 8'h80, 1'b0}, // R6 disabled pins
        {4'd8,  1'b0, 1'b1, 4'h8, 8'h80, 8'h00, 4'h8, 8'h00, 1'b0}, // R8 clear
        {4'd9,  1'b1, 1'b1, 4'h0, 8'hFF, 8'h00, 4'h0, 8'h80, 1'b0}, // R9 locked enable
        {4'd9,  1'b1, 1'b1, 4'h4, 8'h00, 8'h00, 4'h4, 8'hA0, 1'b0}, // R9 locked level
        {4'd10, 1'b0, 1'b1, 4'h0, 8'h10, 8'h00, 4'h0, 8'h10, 1'b0}, // R10 unlocked
        {4'd5,  1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 4'h8, 8'h10, 1'b1}, // R5 low-level match
        {4'd8,  1'b0, 1'b1, 4'h8, 8'h10, 8'h00, 4'h8, 8'h10, 1'b1}, // R8 set wins
        {4'd11, 1'b0, 1'b0, 4'h0, 8'h00, 8'h10, 4'hC, 8'h00, 1'b0}, // R11 unmapped
        {4'd8,  1'b0, 1'b1, 4'h8, 8'h10, 8'h10, 4'h8, 8'h00, 1'b0}  // R8 clear after release
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lock_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [3:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic [7:0] pins_i = '0;
    logic       wake_o;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wake_pin_cfg dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (lock_i),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o),
        .pins_i   (pins_i),
        .wake_o   (wake_o)
    );

    task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input int req, input logic [3:0] a, input logic [7:0] exp);
        rd_addr_i = a;
        #1;
        chk(req, rd_data_o, exp);
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rd_chk(1, 4'h0, 8'h00);
        rd_chk(1, 4'h8, 8'h00);
        chk(1, {7'd0, wake_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(1, 4'h4, 8'h00);
        chk(1, {7'd0, wake_o}, 8'h00);

        for (int v = 0; v < NV; v++) begin
            logic [38:0] e;
            e = VEC[v];
            lock_i    = e[34];
            wr_en_i   = e[33];
            wr_addr_i = e[32:29];
            wr_data_i = e[28:21];
            pins_i    = e[20:13];
            rd_addr_i = e[12:9];
            @(negedge clk);
            chk(int'(e[38:35]), rd_data_o, e[8:1]);
            chk(int'(e[38:35]), {7'd0, wake_o}, {7'd0, e[0]});
        end
        wr_en_i = 1'b0;
        lock_i = 1'b0;

        // R1: mid-run reset with a pending match
        wr_en_i = 1'b1; wr_addr_i = 4'h0; wr_data_i = 8'hF0; pins_i = 8'h00;
        @(negedge clk);
        wr_en_i = 1'b0;
        @(negedge clk);
        chk(1, {7'd0, wake_o}, 8'h01);
        rst_n = 1'b0;
        #1;
        rd_chk(1, 4'h0, 8'h00);
        rd_chk(1, 4'h4, 8'h00);
        rd_chk(1, 4'h8, 8'h00);
        chk(1, {7'd0, wake_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: all pins disabled, every level seen, no wake
        for (int p = 0; p < 16; p++) begin
            pins_i = 8'(p << 4);
            @(negedge clk);
            chk(6, {7'd0, wake_o}, 8'h00);
        end
        rd_chk(6, 4'h8, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule